// File: doc/BRIEF.md
# Circular Window Commit, Wakeup and Dual-Issue Select

This block is the control logic for a circular instruction window, such as a reorder buffer, that is tracked by a head pointer and a tail pointer. It answers three questions in the same cycle. First, which entries may retire now. Second, which source operands are ready. Third, which entries receive one of two functional units. Every answer depends on age, and age is measured from the oldest entry at the head, across the wrap point, up to the youngest entry just before the tail.

The block first rotates the per-entry fields by the head index, so that position zero is the oldest entry. It then runs parallel prefix scans of logarithmic depth over that age order, and rotates the results back to entry order. Cutting the scan at the head in this way is what turns a cyclic segmented prefix into a straight one.

The head pointer is held inside the block. It advances by the number of entries committed in each cycle. The tail is supplied by the allocator.

Top module: `csp_window`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released, `head_o` is 0.
- R2: The occupied entries run from `head_o` up to `tail_i - 1`, wrapping modulo N. `tail_i == head_o` means the window is empty, so at most N-1 entries are occupied. An unoccupied entry never commits, is never granted, never reads as a writer, and its `ready_o` bit is 0.
- R3: `commit_o` marks the unbroken run of done entries that starts at the head. The first occupied entry that is not done stops the run, and no entry younger than it commits.
- R4: At most CMAX entries commit in one cycle. These are the oldest CMAX entries of the done run.
- R5: On each rising clock edge, `head_o` advances by the number of bits set in `commit_o`, modulo N.
- R6: An occupied entry's `ready_o` bit comes from the nearest older occupied entry whose write enable is set and whose destination equals the entry's source register. The bit is 1 if that writer is done and 0 if it is not. Writers further back, and writers younger than the entry, have no effect.
- R7: If no such older writer lies between the head and the entry, `ready_o` is 1. This includes the entry at the head itself.
- R8: An occupied entry with its request bit set is granted only when fewer than two older occupied entries also request. At most two grants are made per cycle.
- R9: Age order follows the head position and not the entry index: an entry with a low index that sits after the wrap point is younger than every entry from the head up to index N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tail_i | input | $clog2(N) | Index of the next free slot |
| done_i | input | N | Per-entry done flag |
| req_i | input | N | Per-entry request for a functional unit |
| dst_en_i | input | N | Per-entry destination write enable |
| dst_i | input | N*$clog2(REGS) | Per-entry destination register, entry j in bits [j*RW +: RW] |
| src_i | input | N*$clog2(REGS) | Per-entry source register, same packing |
| head_o | output | $clog2(N) | Index of the oldest entry |
| commit_o | output | N | Entries retiring this cycle |
| ready_o | output | N | Source operand ready per entry |
| grant_o | output | N | Functional-unit grant per entry |

## Verification
The directed cases each isolate one part of the logic:
- An empty window, with every other input set, shows that occupancy gating works.
- A nearly full window in which every entry is done separates the commit cap from the done run.
- A single not-done entry near the head shows the run stopping at that entry.
- A wakeup layout with a not-done writer, a later done writer of the same register, an unwritten register and a younger writer checks nearest-older selection.

Hundreds of random cycles then vary occupancy, the done and request densities, and the register fields. Because commits keep moving the head, these cycles carry every scan across the wrap point. The bench compares each cycle against a sequential age walk.

// File: rtl/csp_pkg.sv
package csp_pkg;

    typedef enum logic [1:0] {
        SCAN_AND  = 2'd0,
        SCAN_SAT2 = 2'd1,
        SCAN_LAST = 2'd2
    } scan_op_e;

    // older is the prefix over lower ages, newer the prefix over higher ages
    function automatic logic [1:0] scan_join(scan_op_e op, logic [1:0] older, logic [1:0] newer);
        logic [2:0] sum;
        logic [1:0] res;
        sum = {1'b0, older} + {1'b0, newer};
        case (op)
            SCAN_AND:  res = {1'b0, older[0] & newer[0]};
            SCAN_SAT2: res = (sum >= 3'd2) ? 2'd2 : sum[1:0];
            default:   res = newer[1] ? newer : older;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/csp_rot.sv
module csp_rot #(
    parameter int N        = 16,
    parameter int EW       = 1,
    parameter bit DIR_BACK = 1'b0
) (
    input  logic [$clog2(N)-1:0] amt_i,
    input  logic [N*EW-1:0]      data_i,
    output logic [N*EW-1:0]      data_o
);
    localparam int IW = $clog2(N);

    logic [EW-1:0] stg [0:IW][0:N-1];

    for (genvar p = 0; p < N; p++) begin : g_in
        assign stg[0][p] = data_i[p*EW +: EW];
        assign data_o[p*EW +: EW] = stg[IW][p];
    end

    for (genvar b = 0; b < IW; b++) begin : g_stage
        for (genvar p = 0; p < N; p++) begin : g_pos
            localparam int FS  = (p + (1 << b)) % N;
            localparam int BS  = (p - (1 << b) + N) % N;
            localparam int SRC = DIR_BACK ? BS : FS;
            assign stg[b+1][p] = amt_i[b] ? stg[b][SRC] : stg[b][p];
        end
    end
endmodule

// File: rtl/csp_scan.sv
module csp_scan
    import csp_pkg::*;
#(
    parameter int       N  = 16,
    parameter scan_op_e OP = SCAN_AND
) (
    input  logic [N-1:0][1:0] lane_i,
    output logic [N-1:0][1:0] scan_o
);
    localparam int LV = $clog2(N);

    logic [1:0] stg [0:LV][0:N-1];

    for (genvar i = 0; i < N; i++) begin : g_io
        assign stg[0][i] = lane_i[i];
        assign scan_o[i] = stg[LV][i];
    end

    for (genvar l = 0; l < LV; l++) begin : g_lvl
        localparam int D = 1 << l;
        for (genvar i = 0; i < N; i++) begin : g_node
            if (i >= D) begin : g_join
                assign stg[l+1][i] = scan_join(OP, stg[l][i-D], stg[l][i]);
            end else begin : g_pass
                assign stg[l+1][i] = stg[l][i];
            end
        end
    end
endmodule

// File: rtl/csp_window.sv
module csp_window
    import csp_pkg::*;
#(
    parameter int N    = 16,
    parameter int REGS = 8,
    parameter int CMAX = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(N)-1:0]          tail_i,
    input  logic [N-1:0]                  done_i,
    input  logic [N-1:0]                  req_i,
    input  logic [N-1:0]                  dst_en_i,
    input  logic [N*$clog2(REGS)-1:0]     dst_i,
    input  logic [N*$clog2(REGS)-1:0]     src_i,
    output logic [$clog2(N)-1:0]          head_o,
    output logic [N-1:0]                  commit_o,
    output logic [N-1:0]                  ready_o,
    output logic [N-1:0]                  grant_o
);
    localparam int IW = $clog2(N);
    localparam int RW = $clog2(REGS);
    localparam int EW = 3 + 2 * RW;
    localparam int OW = 3;

    typedef struct packed {
        logic [IW-1:0] head;
    } state_t;

    state_t state_d, state_q;

    logic [IW-1:0]      occ;
    logic [N*EW-1:0]    fld_ent, fld_age;
    logic [N-1:0]       done_a, req_a, wen_a, valid_a;
    logic [RW-1:0]      dst_a [N];
    logic [RW-1:0]      src_a [N];
    logic [N-1:0][1:0]  and_lane, and_scan, cnt_lane, cnt_scan;
    logic [N-1:0][1:0]  wr_lane [REGS];
    logic [N-1:0][1:0]  wr_scan [REGS];
    logic [N-1:0]       commit_a, ready_a, grant_a;
    logic [N*OW-1:0]    res_age, res_ent;
    logic [IW:0]        ccnt;

    assign occ = tail_i - state_q.head;

    // pack entry fields, rotate so age 0 is the head entry
    for (genvar j = 0; j < N; j++) begin : g_pack
        assign fld_ent[j*EW +: EW] = {done_i[j], req_i[j], dst_en_i[j],
                                      dst_i[j*RW +: RW], src_i[j*RW +: RW]};
    end

    csp_rot #(.N(N), .EW(EW), .DIR_BACK(1'b0)) u_rot_in (
        .amt_i  (state_q.head),
        .data_i (fld_ent),
        .data_o (fld_age)
    );

    always_comb begin
        for (int p = 0; p < N; p++) begin
            {done_a[p], req_a[p], wen_a[p], dst_a[p], src_a[p]} = fld_age[p*EW +: EW];
            valid_a[p]  = (IW'(p) < occ);
            and_lane[p] = {1'b0, valid_a[p] & done_a[p]};
            cnt_lane[p] = {1'b0, valid_a[p] & req_a[p]};
        end
    end

    csp_scan #(.N(N), .OP(SCAN_AND)) u_scan_commit (
        .lane_i (and_lane),
        .scan_o (and_scan)
    );

    csp_scan #(.N(N), .OP(SCAN_SAT2)) u_scan_sel (
        .lane_i (cnt_lane),
        .scan_o (cnt_scan)
    );

    // one nearest-writer scan per logical register
    for (genvar r = 0; r < REGS; r++) begin : g_reg
        for (genvar p = 0; p < N; p++) begin : g_lane
            assign wr_lane[r][p] = {valid_a[p] & wen_a[p] & (dst_a[p] == RW'(r)), done_a[p]};
        end
        csp_scan #(.N(N), .OP(SCAN_LAST)) u_scan_wr (
            .lane_i (wr_lane[r]),
            .scan_o (wr_scan[r])
        );
    end

    always_comb begin
        logic [1:0] older_req;
        logic [1:0] wr;
        for (int p = 0; p < N; p++) begin
            commit_a[p] = and_scan[p][0] && (p < CMAX);
            older_req   = (p == 0) ? 2'd0 : cnt_scan[(p == 0) ? 0 : p-1];
            grant_a[p]  = valid_a[p] & req_a[p] & (older_req < 2'd2);
            wr          = (p == 0) ? 2'b00 : wr_scan[src_a[p]][(p == 0) ? 0 : p-1];
            ready_a[p]  = valid_a[p] & (wr[1] ? wr[0] : 1'b1);
            res_age[p*OW +: OW] = {commit_a[p], ready_a[p], grant_a[p]};
        end
    end

    csp_rot #(.N(N), .EW(OW), .DIR_BACK(1'b1)) u_rot_out (
        .amt_i  (state_q.head),
        .data_i (res_age),
        .data_o (res_ent)
    );

    always_comb begin
        for (int j = 0; j < N; j++) begin
            {commit_o[j], ready_o[j], grant_o[j]} = res_ent[j*OW +: OW];
        end
    end

    // next head
    always_comb begin
        ccnt = '0;
        for (int p = 0; p < N; p++) begin
            ccnt = ccnt + {{IW{1'b0}}, commit_a[p]};
        end
        state_d      = state_q;
        state_d.head = state_q.head + ccnt[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign head_o = state_q.head;

endmodule

// File: rtl/csp_window_chk.sv
module csp_window_chk #(
    parameter int N    = 16,
    parameter int CMAX = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [$clog2(N)-1:0] tail_i,
    input logic [N-1:0]         done_i,
    input logic [N-1:0]         req_i,
    input logic [$clog2(N)-1:0] head_o,
    input logic [N-1:0]         commit_o,
    input logic [N-1:0]         ready_o,
    input logic [N-1:0]         grant_o
);
    localparam int IW = $clog2(N);

    logic [IW:0] ccnt;
    assign ccnt = (IW+1)'($countones(commit_o));

    a_r3_commit_done: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o & ~done_i) == '0);

    a_r4_commit_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ccnt <= (IW+1)'(CMAX));

    a_r5_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> head_o == IW'($past(head_o) + $past(ccnt[IW-1:0])));

    a_r8_two_grants: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) <= 2);

    a_r8_grant_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);

    a_r2_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_i == head_o) |-> (commit_o == '0 && grant_o == '0 && ready_o == '0));
endmodule

bind csp_window csp_window_chk #(.N(N), .CMAX(CMAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tail_i   (tail_i),
    .done_i   (done_i),
    .req_i    (req_i),
    .head_o   (head_o),
    .commit_o (commit_o),
    .ready_o  (ready_o),
    .grant_o  (grant_o)
);

// File: tb/test_csp_window.sv
`timescale 1ns/1ps
module test_csp_window;
    localparam int N    = 16;
    localparam int REGS = 8;
    localparam int CMAX = 4;
    localparam int IW   = $clog2(N);
    localparam int RW   = $clog2(REGS);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IW-1:0]     tail_i = '0;
    logic [N-1:0]      done_i = '0, req_i = '0, dst_en_i = '0;
    logic [N*RW-1:0]   dst_i = '0, src_i = '0;
    logic [IW-1:0]     head_o;
    logic [N-1:0]      commit_o, ready_o, grant_o;

    always #2 clk = ~clk;

    csp_window #(.N(N), .REGS(REGS), .CMAX(CMAX)) i_csp_window (
        .clk(clk), .rst_n(rst_n), .tail_i(tail_i), .done_i(done_i), .req_i(req_i),
        .dst_en_i(dst_en_i), .dst_i(dst_i), .src_i(src_i), .head_o(head_o),
        .commit_o(commit_o), .ready_o(ready_o), .grant_o(grant_o)
    );

    typedef struct {
        logic [N-1:0]  commit;
        logic [N-1:0]  ready;
        logic [N-1:0]  grant;
        logic [IW-1:0] head;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   hm = 0;
    bit   ended = 0;

    task automatic check_vec(string req, string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) actual=%h expected=%h", req, tag, act, exp);
        end
    endtask

    // sequential age walk from the head
    function automatic exp_t model(string tag);
        exp_t e;
        int occ, idx, cnt, j;
        bit run, r;
        e.commit = '0; e.ready = '0; e.grant = '0;
        e.head = IW'(hm); e.tag = tag;
        occ = (int'(tail_i) - hm + N) % N;
        run = 1; cnt = 0;
        for (int p = 0; p < occ; p++) begin
            idx = (hm + p) % N;
            run = run && done_i[idx] && (p < CMAX);
            e.commit[idx] = run;
            if (req_i[idx]) begin
                if (cnt < 2) e.grant[idx] = 1'b1;
                cnt++;
            end
            r = 1;
            for (int k = p - 1; k >= 0; k--) begin
                j = (hm + k) % N;
                if (dst_en_i[j] && dst_i[j*RW +: RW] == src_i[idx*RW +: RW]) begin
                    r = done_i[j];
                    break;
                end
            end
            e.ready[idx] = r;
        end
        return e;
    endfunction

    task automatic push(string tag);
        exp_t e;
        e = model(tag);
        q.push_back(e);
        hm = (hm + $countones(e.commit)) % N;
    endtask

    // monitor: compare one item per cycle just after inputs settle
    initial begin
        exp_t e;
        forever begin
            wait (q.size() > 0);
            e = q.pop_front();
            #1;
            check_vec("R3/R4 commit", e.tag, commit_o, e.commit);
            check_vec("R6/R7 ready",  e.tag, ready_o,  e.ready);
            check_vec("R8 grant",     e.tag, grant_o,  e.grant);
            check_vec("R5 head",      e.tag, N'(head_o), N'(e.head));
        end
    end

    task automatic set_field(inout logic [N*RW-1:0] v, input int age, input int val);
        v[((hm + age) % N)*RW +: RW] = RW'(val);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [N*RW-1:0] d, s;
        repeat (3) @(negedge clk);
        check_vec("R1 reset head", "in reset", N'(head_o), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_vec("R1 reset head", "after reset", N'(head_o), '0);

        // R2: empty window, all other inputs asserted
        tail_i = IW'(hm); done_i = '1; req_i = '1; dst_en_i = '1;
        push("R2 empty");

        // R4: fifteen done entries, only CMAX commit
        @(negedge clk);
        tail_i = IW'((hm + N - 1) % N);
        req_i = '0; dst_en_i = '0;
        push("R4 cap");

        // R3: done run broken at age 2
        @(negedge clk);
        done_i = '1;
        done_i[(hm + 2) % N] = 1'b0;
        tail_i = IW'((hm + 8) % N);
        push("R3 stop");

        // R8 and R9: head is now past index 0 after earlier commits; requests cross the wrap
        @(negedge clk);
        done_i = '0; req_i = '1;
        tail_i = IW'((hm + 12) % N);
        push("R8 R9 select");

        // R6 and R7: wakeup layout
        @(negedge clk);
        done_i = '0; req_i = '0; dst_en_i = '0; d = '0; s = '0;
        dst_en_i[(hm + 0) % N] = 1'b1; set_field(d, 0, 3);                 // writer r3, not done
        set_field(s, 1, 3);                                                 // waits on age 0
        dst_en_i[(hm + 2) % N] = 1'b1; set_field(d, 2, 3); done_i[(hm + 2) % N] = 1'b1;
        set_field(s, 3, 3);                                                 // nearest is age 2, done
        set_field(s, 4, 5);                                                 // R7 no older writer
        dst_en_i[(hm + 5) % N] = 1'b1; set_field(d, 5, 5);                 // younger writer, ignored
        set_field(s, 6, 5);                                                 // sees age 5, not done
        dst_i = d; src_i = s;
        tail_i = IW'((hm + 7) % N);
        push("R6 R7 wakeup");

        // random cycles, including entries outside the occupied range (R2)
        for (int c = 0; c < 500; c++) begin
            @(negedge clk);
            tail_i = IW'((hm + $urandom_range(0, N - 1)) % N);
            for (int j = 0; j < N; j++) begin
                done_i[j]   = ($urandom % 4) != 0;
                req_i[j]    = ($urandom % 3) == 0;
                dst_en_i[j] = ($urandom % 2) == 0;
                dst_i[j*RW +: RW] = RW'($urandom_range(0, REGS - 1));
                src_i[j*RW +: RW] = RW'($urandom_range(0, REGS - 1));
            end
            push("random");
        end

        wait (q.size() == 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule